// File: doc/BRIEF.md
# Camera Receiver Control and Interrupt Registers

This block is the register front end of a serial camera receiver. A simple 32-bit register port reads and writes it. It holds the core enable and a soft-reset request. It also runs a drain handshake: a busy flag that software polls until the core has settled. It collects single-cycle event pulses from the receiver logic into an interrupt status word whose bits software clears by writing 1. A per-bit enable word and a global enable combine that status into one interrupt line. It also counts received packets for software.

The register port has no back-pressure. A write is taken in the cycle that `csr_wr_en` is high. A read returns data on `csr_rdata` in the cycle after `csr_rd_en`. The receiver side is plain: `evt_pulse` and `pkt_strobe` are one-cycle strobes, and the block never stalls them. The drain length is the parameter `DRAIN_CYCLES` (default 40, below the 100-cycle limit the receiver allows).

Top module: `camrx_csr`

## Requirements
- R1: After reset every register reads 0, and `irq_o`, `core_en_o` and `core_rst_o` are 0.
- R2: Offset 0x00 is the control word. Bit 0 is the core enable and bit 1 is the soft-reset request. Both read back as written, and `core_en_o` is high when bit 0 is set and the drain is not busy.
- R3: A write to 0x00 that raises bit 1 starts a drain. A write that clears bit 0 while it was set also starts a drain. The drain holds `core_rst_o` high and status bit 0 (offset 0x10) at 1 for exactly `DRAIN_CYCLES` cycles, then both return to 0.
- R4: An `evt_pulse` bit sets the matching interrupt status bit at offset 0x24 if that bit is inside mask 0xC07E3FFF. Bits outside the mask always read 0.
- R5: Writing 1 to a bit at 0x24 clears it, and writing 0 leaves it alone. If an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R6: Offset 0x28 is the interrupt enable word. Only bits within mask 0x807E3FFF are stored. Bit 30 cannot be written and reads 0.
- R7: Bit 0 of offset 0x20 is the global interrupt enable and reads back as written.
- R8: `irq_o` is high exactly when the global enable is set and some status bit is set together with its enable bit. A set status bit 30 alone never raises `irq_o`.
- R9: Bits 31:16 of offset 0x10 are a packet count that rises by one for each `pkt_strobe` cycle. Writes to 0x10 change nothing.
- R10: While a drain is busy, the interrupt status word and the packet count are held at 0, and event pulses and packet strobes are discarded.
- R11: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_rd_en | input | 1 | Register read strobe |
| csr_addr | input | 8 | Byte offset of the register |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid the cycle after csr_rd_en |
| evt_pulse | input | 32 | One-cycle event pulses, one per status bit position |
| pkt_strobe | input | 1 | One-cycle pulse per received packet |
| core_en_o | output | 1 | Core enable toward the receiver |
| core_rst_o | output | 1 | Drain / soft reset in progress toward the receiver |
| irq_o | output | 1 | Interrupt request |

## Verification
Two writers can touch one interrupt status bit in the same cycle: an event pulse from the receiver and a write-one-to-clear from software. The bench drives a pulse on a bit during the very cycle it writes 1 to clear that bit. It then reads the status back and expects the bit still set. It then clears the bit with no pulse present and expects 0. A second overlap is tested the same way: an event pulse or packet strobe that arrives while a drain is busy. After the drain ends, the bench expects both the status word and the count to read back as 0.

// File: rtl/camrx_csr_pkg.sv
package camrx_csr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_GIE  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ISR  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h28;

  localparam logic [DATA_W-1:0] ISR_MASK = 32'hC07E_3FFF;
  localparam int unsigned       NOEN_BIT = 30;
  localparam logic [DATA_W-1:0] IEN_MASK = ISR_MASK & ~(32'h1 << NOEN_BIT);

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_GIE, SEL_ISR, SEL_IEN
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_CTRL: return SEL_CTRL;
      OFS_STAT: return SEL_STAT;
      OFS_GIE:  return SEL_GIE;
      OFS_ISR:  return SEL_ISR;
      OFS_IEN:  return SEL_IEN;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/camrx_drain_seq.sv
module camrx_drain_seq #(
  parameter int unsigned DRAIN_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(DRAIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DRAIN_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end else if (busy_q) begin
      if (cnt_q == CNT_LAST) busy_q <= 1'b0;
      cnt_q <= cnt_q - CNT_LAST;
    end
  end

  assign busy_o = busy_q;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o); // R3
  AST_BUSY_MIN2: assert property (@(posedge clk) disable iff (!rst_n)
    (DRAIN_CYCLES > 1 && $rose(busy_o)) |=> busy_o); // R3
endmodule

// File: rtl/camrx_irq_unit.sv
module camrx_irq_unit
  import camrx_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              isr_w1c_i,
  input  logic              ien_wr_i,
  input  logic              gie_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] isr_o,
  output logic [DATA_W-1:0] ien_o,
  output logic              gie_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] isr_q, isr_d, ien_q, clr_vec, set_vec;
  logic              gie_q;

  always_comb begin
    clr_vec = isr_w1c_i ? wdata_i : '0;
    set_vec = evt_i & ISR_MASK;
    if (busy_i) isr_d = '0;
    else        isr_d = (isr_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      ien_q <= '0;
      gie_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      if (ien_wr_i) ien_q <= wdata_i & IEN_MASK;
      if (gie_wr_i) gie_q <= wdata_i[0];
    end
  end

  assign isr_o = isr_q;
  assign ien_o = ien_q;
  assign gie_o = gie_q;
  assign irq_o = gie_q & (|(isr_q & ien_q));

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && (evt_i & ISR_MASK) != '0) |=>
      ((isr_q & $past(evt_i & ISR_MASK)) == $past(evt_i & ISR_MASK))); // R5
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_o); // R8
  AST_BIT30_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_o & ~(32'h1 << NOEN_BIT)) == '0) |-> !irq_o); // R8
  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (isr_o == '0)); // R10
endmodule

// File: rtl/camrx_pkt_counter.sv
module camrx_pkt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             strobe_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (busy_i)   cnt_q <= '0;
    else if (strobe_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;

  AST_PKT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !busy_i) |=> (count_o == $past(count_o) + CNT_W'(1))); // R9
endmodule

// File: rtl/camrx_csr.sv
module camrx_csr
  import camrx_csr_pkg::*;
#(
  parameter int unsigned DRAIN_CYCLES = 40,
  parameter int unsigned PKT_CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr_en,
  input  logic              csr_rd_en,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic [DATA_W-1:0] evt_pulse,
  input  logic              pkt_strobe,
  output logic              core_en_o,
  output logic              core_rst_o,
  output logic              irq_o
);
  localparam int unsigned STAT_PAD = DATA_W - PKT_CNT_W - 1;

  reg_sel_e          sel;
  logic              wr_ctrl, wr_gie, wr_isr, wr_ien;
  logic              en_q, srst_q, drain_start, busy;
  logic [DATA_W-1:0] isr, ien, rd_d;
  logic              gie;
  logic [PKT_CNT_W-1:0] pkt_cnt;

  assign sel     = decode(csr_addr);
  assign wr_ctrl = csr_wr_en && (sel == SEL_CTRL);
  assign wr_gie  = csr_wr_en && (sel == SEL_GIE);
  assign wr_isr  = csr_wr_en && (sel == SEL_ISR);
  assign wr_ien  = csr_wr_en && (sel == SEL_IEN);

  // drain begins on a rising reset request or a falling enable
  assign drain_start = wr_ctrl &&
                       ((csr_wdata[1] && !srst_q) || (!csr_wdata[0] && en_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= csr_wdata[0];
      srst_q <= csr_wdata[1];
    end
  end

  camrx_drain_seq #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_drain (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (drain_start),
    .busy_o  (busy)
  );

  camrx_irq_unit u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_i    (busy),
    .evt_i     (evt_pulse),
    .isr_w1c_i (wr_isr),
    .ien_wr_i  (wr_ien),
    .gie_wr_i  (wr_gie),
    .wdata_i   (csr_wdata),
    .isr_o     (isr),
    .ien_o     (ien),
    .gie_o     (gie),
    .irq_o     (irq_o)
  );

  camrx_pkt_counter #(.CNT_W(PKT_CNT_W)) u_pkt (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_i   (busy),
    .strobe_i (pkt_strobe),
    .count_o  (pkt_cnt)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: rd_d = {{(DATA_W-2){1'b0}}, srst_q, en_q};
      SEL_STAT: rd_d = {pkt_cnt, {STAT_PAD{1'b0}}, busy};
      SEL_GIE:  rd_d = {{(DATA_W-1){1'b0}}, gie};
      SEL_ISR:  rd_d = isr;
      SEL_IEN:  rd_d = ien;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         csr_rdata <= '0;
    else if (csr_rd_en) csr_rdata <= rd_d;
  end

  assign core_en_o  = en_q && !busy;
  assign core_rst_o = busy;

  AST_EN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> !core_en_o); // R2
  AST_DISABLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && en_q && !csr_wdata[0]) |=> core_rst_o); // R3
endmodule

// File: tb/camrx_csr_tb.sv
module camrx_csr_tb;
  localparam int DRAIN = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0, csr_rd_en = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic [31:0] evt_pulse = '0;
  logic        pkt_strobe = 1'b0;
  logic        core_en_o, core_rst_o, irq_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  camrx_csr #(.DRAIN_CYCLES(DRAIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_rd_en(csr_rd_en),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .evt_pulse(evt_pulse), .pkt_strobe(pkt_strobe), .core_en_o(core_en_o),
    .core_rst_o(core_rst_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1;
    csr_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_rd_en = 1'b1; csr_addr = a;
    @(posedge clk); #1;
    d = csr_rdata;
    csr_rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(posedge clk); #1;
    evt_pulse = '0;
  endtask

  task automatic wait_drain(output int n);
    n = 1;
    forever begin
      @(posedge clk); #1;
      if (core_rst_o) n++; else break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 core_en", {31'b0, core_en_o}, 0);
    chk("R1 core_rst", {31'b0, core_rst_o}, 0);
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h10, d); chk("R1 stat", d, 0);
    rd(8'h24, d); chk("R1 isr", d, 0);
    rd(8'h28, d); chk("R1 ien", d, 0);
    rd(8'h20, d); chk("R1 gie", d, 0);
  endtask

  task automatic t_ctrl_and_soft_reset;
    logic [31:0] d; int n;
    wr(8'h00, 32'h1);
    chk("R2 core_en on", {31'b0, core_en_o}, 1);
    rd(8'h00, d); chk("R2 ctrl readback", d, 32'h1);
    wr(8'h00, 32'h3);
    chk("R3 rst high", {31'b0, core_rst_o}, 1);
    chk("R2 en gated while busy", {31'b0, core_en_o}, 0);
    rd(8'h10, d); chk("R3 busy bit", d, 32'h1);
    wait_drain(n); n++;
    chk("R3 soft reset length", n, DRAIN);
    rd(8'h10, d); chk("R3 busy cleared", d, 0);
    chk("R2 en after drain", {31'b0, core_en_o}, 1);
    wr(8'h00, 32'h1);
    chk("R3 clearing request no drain", {31'b0, core_rst_o}, 0);
    wr(8'h00, 32'h0);
    chk("R3 disable starts drain", {31'b0, core_rst_o}, 1);
    wait_drain(n);
    chk("R3 disable drain length", n, DRAIN);
  endtask

  task automatic t_isr;
    logic [31:0] d;
    pulse(32'hFFFF_FFFF);
    rd(8'h24, d); chk("R4 implemented bits only", d, 32'hC07E_3FFF);
    wr(8'h24, 32'h8000_0001);
    rd(8'h24, d); chk("R5 w1c", d, 32'h407E_3FFE);
    @(negedge clk);
    evt_pulse = 32'h0000_0002; csr_wr_en = 1'b1; csr_addr = 8'h24; csr_wdata = 32'h0000_0006;
    @(posedge clk); #1;
    evt_pulse = '0; csr_wr_en = 1'b0;
    rd(8'h24, d); chk("R5 event wins collision", d, 32'h407E_3FFA);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, d); chk("R5 clear all", d, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, d); chk("R6 ien mask", d, 32'h807E_3FFF);
    wr(8'h20, 32'h1);
    rd(8'h20, d); chk("R7 gie readback", d, 32'h1);
    pulse(32'h4000_0000);
    chk("R8 bit30 silent", {31'b0, irq_o}, 0);
    pulse(32'h0000_0400);
    chk("R8 irq raised", {31'b0, irq_o}, 1);
    wr(8'h20, 32'h0);
    chk("R7 gie gates irq", {31'b0, irq_o}, 0);
    wr(8'h20, 32'h1);
    wr(8'h28, 32'h0000_0001);
    chk("R8 disabled bit silent", {31'b0, irq_o}, 0);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h28, 32'h0);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_pkt_and_unmapped;
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); pkt_strobe = 1'b1;
      @(posedge clk); #1; pkt_strobe = 1'b0;
    end
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R9 packet count, write ignored", d, 32'h0005_0000);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R11 unmapped read", d, 0);
    rd(8'h28, d); chk("R11 unmapped write harmless", d, 0);
  endtask

  task automatic t_busy_discard;
    logic [31:0] d; int n;
    pulse(32'h0000_0100);
    wr(8'h00, 32'h2);
    @(negedge clk); evt_pulse = 32'h0000_0200; pkt_strobe = 1'b1;
    @(posedge clk); #1; evt_pulse = '0; pkt_strobe = 1'b0;
    wait_drain(n);
    rd(8'h24, d); chk("R10 isr cleared and events dropped", d, 0);
    rd(8'h10, d); chk("R10 count cleared and strobe dropped", d, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_ctrl_and_soft_reset();
        t_isr();
        t_irq();
        t_pkt_and_unmapped();
        t_busy_discard();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule